// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Lookup

This block keeps the tag side of a small direct-mapped data cache. It has 32 lines. Each line holds one valid bit and one tag. A line covers a 32-byte block, so the total capacity is 1 KB. Data storage, write policy and the backing memory sit outside the block.

A requester presents a word address together with an access strobe. In the same cycle the block reports whether that access hits. On a miss it writes the new tag into the indexed line at the next clock edge, so a repeat access to the same block in the following cycle hits.

Two counters track performance:
- the number of enabled accesses;
- the number of hits among them.

A runtime enable turns the cache off. While it is low, every access reports a miss and nothing is recorded. A debug read port returns the valid bit and tag of any line without disturbing anything.

Top module: `dcache_tag_top`

## Requirements
- R1: After reset every line reads back invalid with a zero tag, and both counters read zero.
- R2: The word address is split into fields:
  - bits [2:0] select the word inside a block and take no part in the lookup;
  - bits [7:3] select one of the 32 lines;
  - bits [31:8] form the 24-bit tag.
- R3: `accHit` is high in the same cycle as the access only when all of these hold:
  - `accStrobe` is high;
  - `cacheOn` is high;
  - the indexed line is valid;
  - the line's stored tag equals the address tag.
- R4: On an enabled strobed miss, the indexed line becomes valid with the address tag at the next rising edge. A repeat access to any word of that block then hits.
- R5: A miss to a line that already holds a different tag replaces that tag. A later access to the replaced block misses.
- R6: `accessCount` rises by exactly one after each edge at which `accStrobe` and `cacheOn` are both high. Otherwise it holds.
- R7: `hitCount` rises by exactly one after each edge at which a hit was reported. Otherwise it holds.
- R8: While `cacheOn` is low, a strobed access reports a miss and leaves the lines and both counters unchanged.
- R9: A cycle with `accStrobe` low reports no hit and changes neither the lines nor the counters.
- R10: `dbgValid` and `dbgTag` show the line selected by `dbgIndex` in the same cycle. Reading them has no effect on the lines or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cacheOn | input | 1 | Runtime enable of the cache |
| accStrobe | input | 1 | Marks a data access this cycle |
| accAddr | input | 32 | Word address of the access |
| accHit | output | 1 | Hit result for the current access |
| accessCount | output | 32 | Number of enabled accesses |
| hitCount | output | 32 | Number of hits |
| dbgIndex | input | 5 | Line selected for debug readout |
| dbgValid | output | 1 | Valid bit of the selected line |
| dbgTag | output | 24 | Tag of the selected line |

## Verification
The embedded assertions check on every cycle that:
- each counter steps by one exactly when its strobe fires and holds otherwise;
- a hit is never reported without an enabled strobe;
- hits never outnumber accesses;
- a miss leaves the indexed line valid with the new tag after the edge.

Some behaviours need a known history of accesses, so only the bench's scenarios can show them:
- whether a given address hits or misses;
- that a replaced block misses afterwards;
- that the word-offset bits are ignored;
- that a disabled access leaves no trace in the lines.

// File: rtl/dcache_tag_pkg.sv
package dcache_tag_pkg;
  typedef struct packed {
    logic install;
    logic countAccess;
    logic countHit;
  } tagCtlStrobes_t;
endpackage

// File: rtl/dcache_tag_ctrl.sv
module dcache_tag_ctrl
  import dcache_tag_pkg::*;
#(
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cacheOn,
  input  logic             accStrobe,
  input  logic             lineValid,
  input  logic [TAG_W-1:0] lineTag,
  input  logic [TAG_W-1:0] addrTag,
  output logic             accHit,
  output tagCtlStrobes_t   ctl
);
  logic enabledAccess;
  logic tagMatch;

  assign enabledAccess   = accStrobe & cacheOn;
  assign tagMatch        = lineValid && (lineTag == addrTag);
  assign accHit          = enabledAccess & tagMatch;
  assign ctl.countAccess = enabledAccess;
  assign ctl.countHit    = enabledAccess & tagMatch;
  assign ctl.install     = enabledAccess & ~tagMatch;

  // R3
  hit_needs_enabled_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accHit |-> (accStrobe && cacheOn && lineValid));

  // R8
  off_no_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cacheOn |-> !ctl.install && !ctl.countAccess);
endmodule

// File: rtl/dcache_tag_dpath.sv
module dcache_tag_dpath
  import dcache_tag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 3,
  parameter int INDEX_W  = 5,
  parameter int CNT_W    = 32,
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W,
  localparam int LINES   = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  accAddr,
  input  tagCtlStrobes_t     ctl,
  input  logic [INDEX_W-1:0] dbgIndex,
  output logic               lineValid,
  output logic [TAG_W-1:0]   lineTag,
  output logic [TAG_W-1:0]   addrTag,
  output logic [CNT_W-1:0]   accessCount,
  output logic [CNT_W-1:0]   hitCount,
  output logic               dbgValid,
  output logic [TAG_W-1:0]   dbgTag
);
  logic [LINES-1:0] validArr;
  logic [TAG_W-1:0] tagArr [LINES];
  logic [INDEX_W-1:0] lineIdx;
  logic unusedOffset;

  assign unusedOffset = ^accAddr[OFFSET_W-1:0];
  assign lineIdx   = accAddr[OFFSET_W +: INDEX_W];
  assign addrTag   = accAddr[ADDR_W-1 -: TAG_W];
  assign lineValid = validArr[lineIdx];
  assign lineTag   = tagArr[lineIdx];
  assign dbgValid  = validArr[dbgIndex];
  assign dbgTag    = tagArr[dbgIndex];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validArr <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else if (ctl.install) begin
      validArr[lineIdx] <= 1'b1;
      tagArr[lineIdx]   <= addrTag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accessCount <= '0;
      hitCount    <= '0;
    end else begin
      if (ctl.countAccess) accessCount <= accessCount + 1'b1;
      if (ctl.countHit)    hitCount    <= hitCount + 1'b1;
    end
  end

  // R4
  miss_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.install |=> validArr[$past(lineIdx)] && (tagArr[$past(lineIdx)] == $past(addrTag)));

  // R6
  access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.countAccess |=> accessCount == $past(accessCount) + 1'b1);

  // R9
  access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.countAccess |=> $stable(accessCount) && $stable(validArr));

  // R7
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.countHit |=> hitCount == $past(hitCount) + 1'b1);

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.countHit |=> $stable(hitCount));

  // R7
  hits_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hitCount <= accessCount);
endmodule

// File: rtl/dcache_tag_top.sv
module dcache_tag_top
  import dcache_tag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 3,
  parameter int INDEX_W  = 5,
  parameter int CNT_W    = 32,
  localparam int TAG_W   = ADDR_W - OFFSET_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cacheOn,
  input  logic               accStrobe,
  input  logic [ADDR_W-1:0]  accAddr,
  output logic               accHit,
  output logic [CNT_W-1:0]   accessCount,
  output logic [CNT_W-1:0]   hitCount,
  input  logic [INDEX_W-1:0] dbgIndex,
  output logic               dbgValid,
  output logic [TAG_W-1:0]   dbgTag
);
  tagCtlStrobes_t ctl;
  logic lineValid;
  logic [TAG_W-1:0] lineTag;
  logic [TAG_W-1:0] addrTag;

  dcache_tag_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cacheOn(cacheOn), .accStrobe(accStrobe),
    .lineValid(lineValid), .lineTag(lineTag), .addrTag(addrTag),
    .accHit(accHit), .ctl(ctl)
  );

  dcache_tag_dpath #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accAddr(accAddr), .ctl(ctl), .dbgIndex(dbgIndex),
    .lineValid(lineValid), .lineTag(lineTag), .addrTag(addrTag),
    .accessCount(accessCount), .hitCount(hitCount),
    .dbgValid(dbgValid), .dbgTag(dbgTag)
  );
endmodule

// File: tb/dcache_tag_top_tb.sv
module dcache_tag_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {cacheOn, accStrobe, expectedHit, address}
  localparam logic [34:0] VEC [NVEC] = '{
    {3'b110, 32'h0000_0000},  // R4 cold miss, line 0
    {3'b111, 32'h0000_0007},  // R2 R4 other word, same block hits
    {3'b110, 32'h0000_0008},  // R2 line 1 miss
    {3'b110, 32'h0000_0100},  // R5 line 0, new tag, evicts
    {3'b110, 32'h0000_0003},  // R5 evicted block misses
    {3'b110, 32'h0000_0105},  // R5 evicted again
    {3'b111, 32'h0000_000F},  // R3 line 1 still hits
    {3'b010, 32'h0000_000F},  // R8 disabled reports miss
    {3'b100, 32'h0000_000F},  // R9 no strobe
    {3'b010, 32'h00AB_CDF8},  // R8 disabled, no install on line 31
    {3'b110, 32'h00AB_CDF8},  // R8 so this misses
    {3'b111, 32'h00AB_CDF9},  // R4 then hits
    {3'b110, 32'hFFFF_FFFF},  // R5 all-ones tag, line 31
    {3'b111, 32'h0000_0106}   // R3 line 0 tag 1 hits
  };

  logic clk = 0;
  logic rst_n = 0;
  logic cacheOn = 0;
  logic accStrobe = 0;
  logic [31:0] accAddr = '0;
  logic accHit;
  logic [31:0] accessCount, hitCount;
  logic [4:0] dbgIndex = '0;
  logic dbgValid;
  logic [23:0] dbgTag;
  int checks = 0;
  int errors = 0;
  int expAcc = 0;
  int expHits = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_tag_top u_dut (
    .clk(clk), .rst_n(rst_n), .cacheOn(cacheOn), .accStrobe(accStrobe),
    .accAddr(accAddr), .accHit(accHit), .accessCount(accessCount),
    .hitCount(hitCount), .dbgIndex(dbgIndex), .dbgValid(dbgValid), .dbgTag(dbgTag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkLine(input string req, input int idx, input logic v, input logic [23:0] t);
    dbgIndex = idx[4:0];
    #1;
    check(req, {39'd0, dbgValid, dbgTag}, {39'd0, v, t});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of all lines and counters
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
        dbgIndex = i[4:0];
        #1;
        if (dbgValid !== 1'b0 || dbgTag !== 24'd0) bad++;
      end
      check("R1 lines invalid", bad, 0);
    end
    check("R1 counters", {accessCount, hitCount}, 64'd0);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check("R6 accessCount", accessCount, expAcc);
      check("R7 hitCount", hitCount, expHits);
      {cacheOn, accStrobe} = VEC[i][34:33];
      accAddr = VEC[i][31:0];
      #1;
      check("R3 accHit", accHit, VEC[i][32]);
      if (VEC[i][34] && VEC[i][33]) expAcc++;
      if (VEC[i][32]) expHits++;
    end
    @(negedge clk);
    accStrobe = 0;
    check("R6 final accessCount", accessCount, 11);
    check("R7 final hitCount", hitCount, 4);

    // R10 debug readout of lines after the sequence
    checkLine("R10 line0", 0, 1'b1, 24'h000001);
    checkLine("R10 line1", 1, 1'b1, 24'h000000);
    checkLine("R5 line31", 31, 1'b1, 24'hFFFFFF);
    checkLine("R10 line5", 5, 1'b0, 24'h000000);

    // R8 disabled access does not install into an empty line
    cacheOn = 0; accStrobe = 1; accAddr = 32'h0012_3428;
    @(negedge clk);
    accStrobe = 0;
    checkLine("R8 no install", 5, 1'b0, 24'h000000);
    check("R8 counters unchanged", {accessCount, hitCount}, {32'd11, 32'd4});

    // R10 debug reads leave counters untouched
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dbgIndex = i[4:0];
    end
    #1;
    check("R10 counters after reads", {accessCount, hitCount}, {32'd11, 32'd4});

    // R1 reset mid-run clears everything
    rst_n = 0;
    #1;
    checkLine("R1 line0 after reset", 0, 1'b0, 24'h000000);
    check("R1 counters after reset", {accessCount, hitCount}, 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule